// File: doc/BRIEF.md
# Threaded Execution Mode Controller

This control unit tells a fetch stage whether it is walking a list of subroutine addresses (threaded mode) or running ordinary instructions (regular mode). The choice rests on a nesting counter. A count of zero is threaded mode: each list word offered by fetch is taken as an implicit call target. The controller requests a jump to that word, and when the target returns it requests a list-pointer advance of `STEP_BYTES` (4 by default). A list word that falls in a reserved address window, by default the low vector area, is not a target. It lifts the counter to one and so hands control to regular code.

In regular mode every call raises the count and every return lowers it. The return that brings the count back to zero resumes threading. If that regular stretch began with a reserved-word escape, the same return also advances the list pointer past the escaped word. A call attempted at the top count is refused: the counter saturates and an overflow exception is requested. Reset leaves the count at one, so the core starts in regular mode. Threading is entered explicitly only through a privileged (supervisor trap) strobe that clears the count.

All pulse outputs are registered and appear one cycle after the input that caused them. `threaded_o` follows the counter register.

Top module: `thread_mode_ctrl`

## Requirements
- R1: After reset the count is one: `threaded_o`, `jump_o`, `ptr_adv_o`, `err_o` and `ovf_o` are all 0.
- R2: `threaded_o` is 1 exactly when the count is zero. A cycle with `thread_enter_i` and `priv_i` both high clears the count, so `threaded_o` is 1 from the next cycle.
- R3: `thread_enter_i` without `priv_i` has no effect on the count.
- R4: In threaded mode with no target outstanding, a valid non-reserved list word gives a one-cycle `jump_o` pulse the next cycle, with `jump_addr_o` equal to the word. The count stays zero.
- R5: In threaded mode with no target outstanding, a valid word for which `(word & RSV_MASK) == RSV_MATCH` (default: 0x000-0x3FF) sets the count to one. `threaded_o` drops and no jump is issued.
- R6: When the count is nonzero, each call adds one and each return subtracts one. `threaded_o` stays 0 until the count reaches zero.
- R7: A return that takes the count from one to zero sets `threaded_o`. It pulses `ptr_adv_o` only when the current regular stretch was entered through a reserved-word escape.
- R8: A return at count zero while a jumped-to target is outstanding pulses `ptr_adv_o` and readies the controller for the next list word.
- R9: A return at count zero with no target outstanding pulses `err_o` and leaves the count at zero.
- R10: A call at the maximum count (255 for 8 bits) pulses `ovf_o` and leaves the count at the maximum, so exactly 255 further returns reach threaded mode.
- R11: When several inputs act in one cycle, only one is honoured. The order is privileged entry, then return, then call, then list word.
- R12: List words are ignored while the count is nonzero or while a target is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call executed |
| ret_i | input | 1 | Subroutine return executed |
| word_valid_i | input | 1 | List word presented by fetch |
| word_i | input | 32 | List word (target address) |
| thread_enter_i | input | 1 | Request to clear the count and enter threading |
| priv_i | input | 1 | Request comes from the supervisor trap path |
| threaded_o | output | 1 | Threaded mode active |
| jump_o | output | 1 | Jump to `jump_addr_o` requested |
| jump_addr_o | output | 32 | Target of the requested jump |
| ptr_adv_o | output | 1 | Advance list pointer by STEP_BYTES |
| err_o | output | 1 | Unmatched return at count zero |
| ovf_o | output | 1 | Nesting overflow exception request |

## Verification
The hardest state to reach from the ports is the saturated counter. From threaded mode the bench issues 255 calls, then one more to raise the overflow. It then proves saturation by counting the returns: 254 of them must leave the core in regular mode and the 255th must resume threading. A second subtle case is a target that makes its own nested calls. Its inner return to zero must resume threading without advancing the list, and only its final return at zero may advance it. The bench builds this by jumping to a target, then calling twice and returning three times.

// File: rtl/thread_mode_pkg.sv
package thread_mode_pkg;
  typedef enum logic [1:0] {
    LS_IDLE   = 2'd0,  // waiting for next list word
    LS_TARGET = 2'd1,  // jumped-to target outstanding
    LS_ESCAPE = 2'd2   // regular stretch entered via reserved word
  } list_state_e;
endpackage

// File: rtl/nest_counter.sv
module nest_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         set_one_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         one_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};
  localparam logic [W-1:0] OneVal = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= OneVal;
    else if (clr_i)                      cnt_q <= '0;
    else if (set_one_i)                  cnt_q <= OneVal;
    else if (inc_i && cnt_q != MaxVal)   cnt_q <= cnt_q + OneVal;
    else if (dec_i && cnt_q != '0)       cnt_q <= cnt_q - OneVal;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == OneVal);
  assign ovf_o  = inc_i && (cnt_q == MaxVal);
endmodule

// File: rtl/rsv_decode.sv
module rsv_decode #(
  parameter int unsigned AW        = 32,
  parameter bit          USE_RANGE = 1'b0,
  parameter logic [AW-1:0] MASK    = 32'hFFFF_FC00,
  parameter logic [AW-1:0] MATCH   = 32'h0000_0000,
  parameter logic [AW-1:0] LO      = 32'h0000_0000,
  parameter logic [AW-1:0] HI      = 32'h0000_03FF
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  generate
    if (USE_RANGE) begin : g_range
      assign hit_o = (addr_i >= LO) && (addr_i <= HI);
    end else begin : g_mask
      assign hit_o = ((addr_i & MASK) == MATCH);
    end
  endgenerate
endmodule

// File: rtl/thread_mode_ctrl.sv
module thread_mode_ctrl
  import thread_mode_pkg::*;
#(
  parameter int unsigned   CNT_W      = 8,
  parameter int unsigned   AW         = 32,
  parameter int unsigned   STEP_BYTES = 4,
  parameter logic [AW-1:0] RSV_MASK   = 32'hFFFF_FC00,
  parameter logic [AW-1:0] RSV_MATCH  = 32'h0000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          word_valid_i,
  input  logic [AW-1:0] word_i,
  input  logic          thread_enter_i,
  input  logic          priv_i,
  output logic          threaded_o,
  output logic          jump_o,
  output logic [AW-1:0] jump_addr_o,
  output logic          ptr_adv_o,
  output logic          err_o,
  output logic          ovf_o
);
  localparam int unsigned StepBytes = STEP_BYTES;  // consumer adds this on ptr_adv_o

  logic [CNT_W-1:0] cnt;
  logic cnt_zero, cnt_one, cnt_ovf, rsv_hit;
  logic ev_enter, ev_ret, ev_call, ev_word, ev_esc, ev_tgt;
  logic adv_d, err_d;
  list_state_e st_q, st_d;

  // one event per cycle: enter > ret > call > word
  assign ev_enter = thread_enter_i && priv_i;
  assign ev_ret   = !ev_enter && ret_i;
  assign ev_call  = !ev_enter && !ret_i && call_i;
  assign ev_word  = !ev_enter && !ret_i && !call_i && word_valid_i
                    && cnt_zero && (st_q == LS_IDLE);
  assign ev_esc   = ev_word && rsv_hit;
  assign ev_tgt   = ev_word && !rsv_hit;

  rsv_decode #(
    .AW(AW), .USE_RANGE(1'b0), .MASK(RSV_MASK), .MATCH(RSV_MATCH),
    .LO('0), .HI('0)
  ) u_rsv (
    .addr_i(word_i),
    .hit_o (rsv_hit)
  );

  nest_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (ev_enter),
    .set_one_i(ev_esc),
    .inc_i    (ev_call),
    .dec_i    (ev_ret && !cnt_zero),
    .cnt_o    (cnt),
    .zero_o   (cnt_zero),
    .one_o    (cnt_one),
    .ovf_o    (cnt_ovf)
  );

  always_comb begin
    st_d  = st_q;
    adv_d = 1'b0;
    err_d = 1'b0;
    if (ev_enter) begin
      st_d = LS_IDLE;
    end else if (ev_ret) begin
      if (cnt_zero) begin
        if (st_q == LS_TARGET) begin
          adv_d = 1'b1;
          st_d  = LS_IDLE;
        end else begin
          err_d = 1'b1;
        end
      end else if (cnt_one && st_q == LS_ESCAPE) begin
        adv_d = 1'b1;
        st_d  = LS_IDLE;
      end
    end else if (ev_esc) begin
      st_d = LS_ESCAPE;
    end else if (ev_tgt) begin
      st_d = LS_TARGET;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= LS_IDLE;
      jump_o      <= 1'b0;
      jump_addr_o <= '0;
      ptr_adv_o   <= 1'b0;
      err_o       <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      st_q      <= st_d;
      jump_o    <= ev_tgt;
      ptr_adv_o <= adv_d;
      err_o     <= err_d;
      ovf_o     <= cnt_ovf;
      if (ev_tgt) jump_addr_o <= word_i;
    end
  end

  assign threaded_o = cnt_zero;

  logic unused_ok;
  assign unused_ok = ^{cnt, StepBytes[0]};
endmodule

// File: rtl/thread_mode_chk.sv
module thread_mode_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          call_i,
  input logic          ret_i,
  input logic          word_valid_i,
  input logic [AW-1:0] word_i,
  input logic          thread_enter_i,
  input logic          priv_i,
  input logic          threaded_o,
  input logic          jump_o,
  input logic [AW-1:0] jump_addr_o,
  input logic          ptr_adv_o,
  input logic          err_o,
  input logic          ovf_o
);
  assert_enter_threads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thread_enter_i && priv_i) |=> threaded_o);

  assert_jump_from_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && !call_i && !ret_i && !thread_enter_i) ##1 jump_o
      |-> (jump_addr_o == $past(word_i)) && threaded_o);

  assert_call_regular_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !(thread_enter_i && priv_i)) |=> !threaded_o);

  assert_adv_threaded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_adv_o |-> threaded_o);

  assert_err_threaded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> threaded_o);

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !threaded_o);

  assert_single_event_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({jump_o, ptr_adv_o, err_o, ovf_o}));

  logic unused_ok;
  assign unused_ok = ^{word_valid_i, word_i};
endmodule

bind thread_mode_ctrl thread_mode_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
  .word_valid_i(word_valid_i), .word_i(word_i),
  .thread_enter_i(thread_enter_i), .priv_i(priv_i),
  .threaded_o(threaded_o), .jump_o(jump_o), .jump_addr_o(jump_addr_o),
  .ptr_adv_o(ptr_adv_o), .err_o(err_o), .ovf_o(ovf_o)
);

// File: tb/tb_thread_mode_ctrl.sv
module tb_thread_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call, ret, wv, enter, priv;
  logic [31:0] word;
  logic threaded, jump, adv, err, ovf;
  logic [31:0] jaddr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  thread_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret),
    .word_valid_i(wv), .word_i(word), .thread_enter_i(enter), .priv_i(priv),
    .threaded_o(threaded), .jump_o(jump), .jump_addr_o(jaddr),
    .ptr_adv_o(adv), .err_o(err), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive for one cycle, sample at the next falling edge
  task automatic step(input logic c, input logic r, input logic v,
                      input logic [31:0] w, input logic e, input logic p);
    call = c; ret = r; wv = v; word = w; enter = e; priv = p;
    @(negedge clk);
    call = 0; ret = 0; wv = 0; word = '0; enter = 0; priv = 0;
  endtask

  task automatic t_reset;
    chk("R1 threaded", {31'b0, threaded}, 0);
    chk("R1 pulses", {28'b0, jump, adv, err, ovf}, 0);
  endtask

  task automatic t_supervisor;
    step(0, 0, 0, 0, 1, 0);
    chk("R3 enter without priv", {31'b0, threaded}, 0);
    step(1, 0, 0, 0, 0, 0);            // count 2
    step(0, 0, 0, 0, 1, 1);
    chk("R2 enter with priv", {31'b0, threaded}, 1);
  endtask

  task automatic t_target;
    step(0, 0, 1, 32'h1000, 0, 0);
    chk("R4 jump", {31'b0, jump}, 1);
    chk("R4 addr", jaddr, 32'h1000);
    chk("R4 threaded", {31'b0, threaded}, 1);
    step(0, 0, 1, 32'h2000, 0, 0);
    chk("R12 word while target", {31'b0, jump}, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R8 adv", {31'b0, adv}, 1);
    step(0, 1, 0, 0, 0, 0);
    chk("R9 err", {31'b0, err}, 1);
    chk("R9 still threaded", {31'b0, threaded}, 1);
    step(0, 0, 1, 32'h2000, 0, 0);
    chk("R9 count stayed zero", {31'b0, jump}, 1);
    step(0, 1, 0, 0, 0, 0);
    chk("R8 adv second", {31'b0, adv}, 1);
  endtask

  task automatic t_nested_target;
    step(0, 0, 1, 32'h3000, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R6 call leaves threading", {31'b0, threaded}, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R6 one return still regular", {31'b0, threaded}, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R7 resume threaded", {31'b0, threaded}, 1);
    chk("R7 no adv inside target", {31'b0, adv}, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R8 adv after target", {31'b0, adv}, 1);
  endtask

  task automatic t_escape;
    step(0, 0, 1, 32'h0000_0100, 0, 0);
    chk("R5 no jump", {31'b0, jump}, 0);
    chk("R5 regular", {31'b0, threaded}, 0);
    step(0, 0, 1, 32'h4000, 0, 0);
    chk("R12 word in regular", {31'b0, jump}, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R6 nested regular", {31'b0, threaded}, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R7 threaded after escape", {31'b0, threaded}, 1);
    chk("R7 adv after escape", {31'b0, adv}, 1);
  endtask

  task automatic t_priority;
    step(1, 0, 1, 32'h5000, 0, 0);
    chk("R11 call beats word", {31'b0, jump}, 0);
    chk("R11 call counted", {31'b0, threaded}, 0);
    step(1, 1, 0, 0, 0, 0);
    chk("R11 ret beats call", {31'b0, threaded}, 1);
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 1, 1);
    chk("R11 enter beats ret", {31'b0, threaded}, 1);
    chk("R11 enter no err", {31'b0, err}, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 255; i++) step(1, 0, 0, 0, 0, 0);
    chk("R10 no ovf below max", {31'b0, ovf}, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R10 ovf", {31'b0, ovf}, 1);
    for (int i = 0; i < 254; i++) step(0, 1, 0, 0, 0, 0);
    chk("R10 saturated count", {31'b0, threaded}, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R10 threaded after 255", {31'b0, threaded}, 1);
  endtask

  initial begin
    call = 0; ret = 0; wv = 0; word = '0; enter = 0; priv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_supervisor();
    t_target();
    t_nested_target();
    t_escape();
    t_priority();
    t_overflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule